// File: doc/BRIEF.md
# Serial Clock Recovery DPLL

This block recovers bit timing from a serial data line that is sampled on a reference clock-enable running at sixteen times the bit rate. It counts reference ticks inside each bit period, watches a short window around the expected bit boundary for a data transition, and nudges its phase toward any transition it finds there. Once per bit it emits a one-cycle sample strobe at mid-bit, which a downstream receiver uses to capture the data value.

Two line codes are handled, chosen by a mode input. For NRZI, where long runs without transitions are legal, a missing boundary edge only counts as a miss after a programmable number of quiet bit times. For biphase (FM) coding, where every bit boundary carries a transition, each empty window is a miss, and phase correction is applied only on every other boundary. One miss sets a sticky latch. Two misses in a row set a second latch and throw the loop back into search, where it waits for a fresh edge to lock on. Both latches clear only when the enable is dropped.

Top module: `dpll_clk_recovery`

## Requirements
- R1: While `dpll_en` is low the loop sits in search, `bit_stb` stays low, `locked` is low and both miss latches are cleared, whatever `rx_in` does.
- R2: In search, the first tick on which `rx_in` differs from its value at the previous tick locks the loop; that tick is phase 0, `locked` goes high after it, and `bit_stb` is high for one clock in the cycle after the tick at phase 8, then again every 16 ticks.
- R3: An edge at phase 14 or 15 advances the phase by one extra tick, an edge at phase 1 or 2 holds the phase for one tick, an edge at phase 0 changes nothing, at most one such correction is made per boundary window, and edges at phases 3 to 13 have no effect on timing.
- R4: With `fm_sel` high, corrections are applied only on the second, fourth, sixth... boundary after lock, and every boundary window (phases 14 to 2) with no edge is a miss event.
- R5: With `fm_sel` low, a miss event occurs only when `gap_lim` consecutive boundary windows pass with no edge (a value of 0 acts as 1); a window with an edge restarts the count.
- R6: A miss event sets `miss_one`, which then stays high while `dpll_en` stays high, even after later edges.
- R7: Two miss events with no edge-bearing window between them set `miss_two` and return the loop to search, so strobes stop until the next edge relocks it.
- R8: Ticks are only those clocks with `tick_en` high; on other clocks no phase, lock or latch state changes.
- R9: `locked` reports whether the loop is tracking (high) or searching (low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Reference tick, 16 per bit |
| dpll_en | input | 1 | Run enable; low clears the loop and latches |
| fm_sel | input | 1 | Line code: 1 biphase, 0 NRZI |
| rx_in | input | 1 | Serial data, synchronous to clk |
| gap_lim | input | GAP_W | NRZI quiet bits before a miss |
| bit_stb | output | 1 | Mid-bit sample strobe |
| locked | output | 1 | Loop is tracking |
| miss_one | output | 1 | Sticky: one miss event seen |
| miss_two | output | 1 | Sticky: two successive misses seen |

## Verification
The bench pins down the strobe position after lock and after single early, late and out-of-window edges; a loop that corrected by more than one tick, corrected twice in one window, or reacted to mid-bit edges would move the second strobe off ticks 23, 24 or 25. Quiet NRZI runs one bit short of and exactly at the gap limit separate an off-by-one miss counter, and a long quiet run shows whether the second miss drops lock and a later edge relocks. Biphase streams with a drifting bit period show whether correction is truly applied on alternate boundaries only, since a loop correcting every boundary would never miss. A slowed tick enable and an enable toggle confirm that state only moves on ticks and that the latches clear only on disable.

// File: rtl/dpll_clk_pkg.sv
package dpll_clk_pkg;

    // Loop state: hunting for a first edge, or tracking bit boundaries.
    typedef enum logic {
        MODE_HUNT  = 1'b0,
        MODE_TRACK = 1'b1
    } dpll_mode_e;

endpackage

// File: rtl/dpll_edge_det.sv
module dpll_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic rx_in,
    output logic edge_tick
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_en) begin
            st_d.prev = rx_in;
        end
        edge_tick = tick_en & (rx_in ^ st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: the remembered level only moves on a tick
    a_r8_prev_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(st_q.prev));

endmodule

// File: rtl/dpll_phase.sv
module dpll_phase
    import dpll_clk_pkg::*;
#(
    parameter int unsigned BIT_TICKS = 16,
    parameter int unsigned WIN_PRE   = 2,
    parameter int unsigned WIN_POST  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic dpll_en,
    input  logic fm_sel,
    input  logic edge_tick,
    input  logic drop_lock,
    output logic locked,
    output logic win_close,
    output logic win_hit,
    output logic bit_stb
);

    localparam int unsigned PH_W = $clog2(BIT_TICKS);
    localparam logic [PH_W-1:0] LAST_PH  = PH_W'(BIT_TICKS - 1);
    localparam logic [PH_W-1:0] EARLY_PH = PH_W'(BIT_TICKS - WIN_PRE);
    localparam logic [PH_W-1:0] LATE_PH  = PH_W'(WIN_POST);
    localparam logic [PH_W-1:0] CLOSE_PH = PH_W'(WIN_POST + 1);
    localparam logic [PH_W-1:0] STB_PH   = PH_W'(BIT_TICKS / 2);

    typedef struct packed {
        dpll_mode_e      mode;
        logic [PH_W-1:0] phase;
        logic            hit;
        logic            alt;
        logic            stb;
    } ph_st_t;

    ph_st_t st_d, st_q;

    function automatic logic [PH_W-1:0] ph_inc(input logic [PH_W-1:0] p);
        if (p == LAST_PH) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    logic tracking;
    logic early_edge;
    logic late_edge;
    logic in_window;
    logic may_correct;

    always_comb begin
        tracking    = (st_q.mode == MODE_TRACK);
        early_edge  = (st_q.phase >= EARLY_PH);
        late_edge   = (st_q.phase != '0) && (st_q.phase <= LATE_PH);
        in_window   = early_edge || (st_q.phase <= LATE_PH);
        may_correct = !fm_sel || st_q.alt;
        win_close   = tick_en && tracking && (st_q.phase == CLOSE_PH);
        win_hit     = st_q.hit;

        st_d     = st_q;
        st_d.stb = 1'b0;

        if (!dpll_en) begin
            st_d = '0;
        end else if (tick_en) begin
            if (!tracking) begin
                if (edge_tick) begin
                    st_d.mode  = MODE_TRACK;
                    st_d.phase = ph_inc('0);
                    st_d.hit   = 1'b1;
                    st_d.alt   = 1'b0;
                end
            end else begin
                st_d.phase = ph_inc(st_q.phase);
                if (st_q.phase == STB_PH) begin
                    st_d.stb = 1'b1;
                end
                if (edge_tick && in_window && !st_q.hit) begin
                    st_d.hit = 1'b1;
                    if (may_correct) begin
                        if (early_edge) begin
                            st_d.phase = ph_inc(ph_inc(st_q.phase));
                        end else if (late_edge) begin
                            st_d.phase = st_q.phase;
                        end
                    end
                end
                if (win_close) begin
                    st_d.hit = 1'b0;
                    st_d.alt = ~st_q.alt;
                end
                if (drop_lock) begin
                    st_d.mode  = MODE_HUNT;
                    st_d.phase = '0;
                    st_d.hit   = 1'b0;
                    st_d.alt   = 1'b0;
                end
            end
        end

        locked  = tracking;
        bit_stb = st_q.stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: nothing advances on a clock without a tick
    a_r8_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (dpll_en && !tick_en) |=> ($stable(st_q.phase) && $stable(st_q.mode)));

    // R1: a disabled loop is searching and silent on the next clock
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dpll_en |=> (st_q.mode == MODE_HUNT && !bit_stb));

    // R3: a tracking tick moves the phase by 0, 1 or 2 ticks
    a_r3_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && dpll_en && tracking && !drop_lock) |=>
        (((int'(st_q.phase) + int'(BIT_TICKS) - int'($past(st_q.phase))) % int'(BIT_TICKS)) <= 2));

    // R2: the strobe is a single-clock pulse
    a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

endmodule

// File: rtl/dpll_miss.sv
module dpll_miss #(
    parameter int unsigned GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dpll_en,
    input  logic             fm_sel,
    input  logic [GAP_W-1:0] gap_lim,
    input  logic             win_close,
    input  logic             win_hit,
    output logic             drop_lock,
    output logic             miss_one,
    output logic             miss_two
);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             consec;
        logic             m1;
        logic             m2;
    } miss_st_t;

    miss_st_t st_d, st_q;

    logic [GAP_W-1:0] lim_eff;
    logic [GAP_W:0]   gap_next;
    logic             miss_evt;

    always_comb begin
        lim_eff   = (gap_lim == '0) ? GAP_W'(1) : gap_lim;
        gap_next  = {1'b0, st_q.gap} + 1'b1;
        miss_evt  = win_close && !win_hit && (fm_sel || (gap_next >= {1'b0, lim_eff}));
        drop_lock = miss_evt && st_q.consec;

        st_d = st_q;
        if (!dpll_en) begin
            st_d = '0;
        end else if (win_close) begin
            if (win_hit) begin
                st_d.gap    = '0;
                st_d.consec = 1'b0;
            end else if (miss_evt) begin
                st_d.gap = '0;
                st_d.m1  = 1'b1;
                if (st_q.consec) begin
                    st_d.m2     = 1'b1;
                    st_d.consec = 1'b0;
                end else begin
                    st_d.consec = 1'b1;
                end
            end else begin
                st_d.gap = gap_next[GAP_W-1:0];
            end
        end

        miss_one = st_q.m1;
        miss_two = st_q.m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the second latch never stands without the first
    a_r7_two_implies_one: assert property (@(posedge clk) disable iff (!rst_n)
        miss_two |-> miss_one);

    // R6: the first latch is sticky while enabled
    a_r6_one_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dpll_en && miss_one) |=> miss_one);

    // R1: disabling clears both latches
    a_r1_latches_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !dpll_en |=> (!miss_one && !miss_two));

    // R5: a latch only rises after a closing window that saw no edge
    a_r5_miss_after_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_one) |-> ($past(win_close) && !$past(win_hit)));

    // R4: in biphase mode every empty window is a miss
    a_r4_fm_empty_window_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (dpll_en && fm_sel && win_close && !win_hit) |=> miss_one);

endmodule

// File: rtl/dpll_clk_recovery.sv
module dpll_clk_recovery #(
    parameter int unsigned BIT_TICKS = 16,
    parameter int unsigned WIN_PRE   = 2,
    parameter int unsigned WIN_POST  = 2,
    parameter int unsigned GAP_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             dpll_en,
    input  logic             fm_sel,
    input  logic             rx_in,
    input  logic [GAP_W-1:0] gap_lim,
    output logic             bit_stb,
    output logic             locked,
    output logic             miss_one,
    output logic             miss_two
);

    logic edge_tick;
    logic drop_lock;
    logic win_close;
    logic win_hit;

    dpll_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .rx_in     (rx_in),
        .edge_tick (edge_tick)
    );

    dpll_phase #(
        .BIT_TICKS (BIT_TICKS),
        .WIN_PRE   (WIN_PRE),
        .WIN_POST  (WIN_POST)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .dpll_en   (dpll_en),
        .fm_sel    (fm_sel),
        .edge_tick (edge_tick),
        .drop_lock (drop_lock),
        .locked    (locked),
        .win_close (win_close),
        .win_hit   (win_hit),
        .bit_stb   (bit_stb)
    );

    dpll_miss #(
        .GAP_W (GAP_W)
    ) u_miss (
        .clk       (clk),
        .rst_n     (rst_n),
        .dpll_en   (dpll_en),
        .fm_sel    (fm_sel),
        .gap_lim   (gap_lim),
        .win_close (win_close),
        .win_hit   (win_hit),
        .drop_lock (drop_lock),
        .miss_one  (miss_one),
        .miss_two  (miss_two)
    );

    // R7: the second miss takes the loop out of tracking at once
    a_r7_two_misses_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_two) |-> !locked);

    // R9: a strobe is only produced by a loop that was tracking
    a_r9_strobe_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $past(locked));

endmodule

// File: tb/dpll_clk_recovery_tb_top.sv
module dpll_clk_recovery_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       dpll_en = 1'b0;
    logic       fm_sel = 1'b0;
    logic       rx_in = 1'b0;
    logic [3:0] gap_lim = 4'd6;
    logic       bit_stb;
    logic       locked;
    logic       miss_one;
    logic       miss_two;

    int n_chk = 0;
    int n_bad = 0;
    int stb_seen = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dpll_clk_recovery dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .dpll_en  (dpll_en),
        .fm_sel   (fm_sel),
        .rx_in    (rx_in),
        .gap_lim  (gap_lim),
        .bit_stb  (bit_stb),
        .locked   (locked),
        .miss_one (miss_one),
        .miss_two (miss_two)
    );

    typedef struct packed {
        logic [1:0]  div;
        logic        fm;
        logic [3:0]  lim;
        logic [4:0]  per;
        logic [4:0]  nb;
        logic [15:0] bm;
        logic [15:0] mm;
        logic [7:0]  stb;
        logic        m1;
        logic        m2;
    } vec_t;

    // div, fm, limit, period, bits, boundary toggles, mid toggles, strobes (FF = skip), miss1, miss2
    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b0, 4'd6, 5'd16, 5'd12, 16'hFFFF, 16'h0000, 8'd12, 1'b0, 1'b0}, // R2 steady NRZI
        '{2'd1, 1'b0, 4'd6, 5'd17, 5'd16, 16'hFFFF, 16'h0000, 8'd16, 1'b0, 1'b0}, // R3 slow line
        '{2'd1, 1'b0, 4'd6, 5'd15, 5'd16, 16'hFFFF, 16'h0000, 8'd16, 1'b0, 1'b0}, // R3 fast line
        '{2'd1, 1'b0, 4'd6, 5'd16, 5'd12, 16'h0FC1, 16'h0000, 8'd12, 1'b0, 1'b0}, // R5 five quiet bits
        '{2'd1, 1'b0, 4'd6, 5'd16, 5'd12, 16'h0F81, 16'h0000, 8'd12, 1'b1, 1'b0}, // R5 R6 six quiet bits
        '{2'd1, 1'b0, 4'd6, 5'd16, 5'd16, 16'hE001, 16'h0000, 8'd15, 1'b1, 1'b1}, // R7 twelve quiet bits
        '{2'd1, 1'b0, 4'd2, 5'd16, 5'd8,  16'h00F9, 16'h0000, 8'd8,  1'b1, 1'b0}, // R5 limit two
        '{2'd3, 1'b0, 4'd6, 5'd16, 5'd10, 16'hFFFF, 16'h0000, 8'd10, 1'b0, 1'b0}, // R8 sparse ticks
        '{2'd1, 1'b1, 4'd6, 5'd16, 5'd12, 16'hFFFF, 16'h0A5A, 8'd12, 1'b0, 1'b0}, // R4 biphase data
        '{2'd1, 1'b1, 4'd6, 5'd16, 5'd12, 16'hFFDF, 16'h0000, 8'd12, 1'b1, 1'b0}, // R4 R6 one gap
        '{2'd1, 1'b1, 4'd6, 5'd16, 5'd12, 16'hFF9F, 16'h0000, 8'd11, 1'b1, 1'b1}, // R7 two gaps
        '{2'd1, 1'b1, 4'd6, 5'd17, 5'd10, 16'hFFFF, 16'h0000, 8'hFF, 1'b1, 1'b1}  // R4 drift
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clk_step();
        @(negedge clk);
        if (bit_stb) stb_seen++;
    endtask

    task automatic do_tick(input int div);
        tick_en = 1'b1;
        clk_step();
        tick_en = 1'b0;
        for (int j = 1; j < div; j++) clk_step();
    endtask

    task automatic restart(input logic fm, input logic [3:0] lim, input int div);
        dpll_en = 1'b0;
        tick_en = 1'b0;
        clk_step();
        clk_step();
        fm_sel  = fm;
        gap_lim = lim;
        dpll_en = 1'b1;
        stb_seen = 0;
        for (int j = 0; j < 4; j++) do_tick(div);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        restart(v.fm, v.lim, int'(v.div));
        for (int b = 0; b < int'(v.nb); b++) begin
            for (int t = 0; t < int'(v.per); t++) begin
                if (t == 0 && v.bm[b]) rx_in = ~rx_in;
                if (t == 8 && v.fm && v.mm[b]) rx_in = ~rx_in;
                do_tick(int'(v.div));
            end
        end
        if (v.stb != 8'hFF) chk($sformatf("R2 R3 vec%0d strobes", idx), stb_seen, int'(v.stb));
        chk($sformatf("R6 vec%0d miss_one", idx), int'(miss_one), int'(v.m1));
        chk($sformatf("R7 vec%0d miss_two", idx), int'(miss_two), int'(v.m2));
        chk($sformatf("R9 vec%0d locked", idx), int'(locked), 1);
    endtask

    // Lock on a toggle at tick 0, apply further toggles, record first three strobe ticks
    task automatic probe(input logic fm, input logic [63:0] tog,
                         output int s0, output int s1, output int s2);
        int n;
        restart(fm, 4'd6, 1);
        s0 = -1; s1 = -1; s2 = -1; n = 0;
        for (int k = 0; k < 48; k++) begin
            if (tog[k]) rx_in = ~rx_in;
            do_tick(1);
            if (bit_stb) begin
                if (n == 0) s0 = k;
                else if (n == 1) s1 = k;
                else if (n == 2) s2 = k;
                n++;
            end
        end
    endtask

    initial begin
        int s0, s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clk_step();
        // R1 R9: reset state
        chk("R1 reset bit_stb", int'(bit_stb), 0);
        chk("R9 reset locked", int'(locked), 0);
        chk("R6 reset miss_one", int'(miss_one), 0);
        chk("R7 reset miss_two", int'(miss_two), 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R1 R6: latches hold until disable, then clear; disabled loop ignores the line
        chk("R6 latch held before disable", int'(miss_one), 1);
        dpll_en = 1'b0;
        stb_seen = 0;
        for (int k = 0; k < 40; k++) begin
            if (k % 5 == 0) rx_in = ~rx_in;
            do_tick(1);
        end
        chk("R1 no strobe while disabled", stb_seen, 0);
        chk("R1 not locked while disabled", int'(locked), 0);
        chk("R1 miss_one cleared", int'(miss_one), 0);
        chk("R1 miss_two cleared", int'(miss_two), 0);
        dpll_en = 1'b1;
        do_tick(1);
        do_tick(1);
        chk("R2 search after enable", int'(locked), 0);
        chk("R6 latch stays clear after enable", int'(miss_one), 0);

        // R2: strobe placement after lock
        probe(1'b0, 64'h1 | 64'h10000, s0, s1, s2);
        chk("R2 first strobe tick", s0, 8);
        chk("R2 second strobe tick", s1, 24);
        chk("R9 locked after edge", int'(locked), 1);

        // R3: early edge at phase 15
        probe(1'b0, 64'h1 | 64'h8000, s0, s1, s2);
        chk("R3 early edge strobe", s1, 23);
        // R3: late edge at phase 1
        probe(1'b0, 64'h1 | 64'h20000, s0, s1, s2);
        chk("R3 late edge strobe", s1, 25);
        // R3: edges at phases 5 and 12 ignored
        probe(1'b0, 64'h1 | 64'h20 | 64'h1000 | 64'h10000, s0, s1, s2);
        chk("R3 out-of-window edges ignored", s1, 24);
        // R3: one correction per window (phase 15 then phase 1)
        probe(1'b0, 64'h1 | 64'h8000 | 64'h10000, s0, s1, s2);
        chk("R3 single correction per window", s1, 23);

        // R4: biphase corrects on the second boundary
        probe(1'b1, 64'h1 | 64'h20000, s0, s1, s2);
        chk("R4 fm corrects second boundary", s1, 25);
        // R4: biphase skips the third boundary, NRZI does not
        probe(1'b1, 64'h1 | 64'h10000 | 64'h2_0000_0000, s0, s1, s2);
        chk("R4 fm skips third boundary", s2, 40);
        probe(1'b0, 64'h1 | 64'h10000 | 64'h2_0000_0000, s0, s1, s2);
        chk("R3 nrzi corrects third boundary", s2, 41);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule